// File: doc/BRIEF.md
# Core idle entry/exit sequencer

This controller walks a single processor core through its low-power phases and back. A request, together with a two-bit mode, starts the walk. Software-side preparation (cache cleaning and the like) runs in a preparation phase that a pending wake-up can still cancel. The controller then commits to entry and gates the core clock. Depending on the mode, it also lowers the supply to a retention level, or removes the supply and holds the core in reset. It then waits in idle for a wake-up. The exit reverses the rail change and confirms that the cache hierarchy has left standby before the core clock and reset are released.

Each supply-rail change is acknowledged by a power-good input. A programmable cycle limit flags an acknowledge that never arrives. A one-cycle pulse marks a cancelled sequence, and a second pulse marks a completed resume. Cluster-wide collapse, external resource management and cache cleaning are not part of this block. They reach it only as acknowledge inputs.

Top module: `core_idle_seq`

## Requirements
- R1: The phase output takes the codes run=0, prepare=1, entry=2, idle=3, exit=4, always in the order run, prepare, entry, idle, exit, run. A cycle in run without a request stays in run. A request in run moves to prepare on the next edge when skip_prep is low.
- R2: Prepare stays until prep_done. A wake high in prepare returns to run on the next edge, and it takes priority over prep_done. abort_pulse is high for exactly the one cycle after that edge.
- R3: Once in entry, wake is ignored until idle is reached. If wake is still high in idle, exit begins on the following edge.
- R4: Idle lasts for any number of cycles while wake is low, and it ends only on wake.
- R5: For standby (mode 0), entry lasts one cycle. clk_gate is high from entry through exit. cache_stby is high only in idle while all_idle is high. Exit holds clk_gate until cache_ack is seen, and a cache_ack seen in idle is ignored.
- R6: For retention (mode 1), ret_en is high in entry and idle. Entry waits for pwr_ack. In exit, ret_en drops and pwr_ack is awaited before cache_ack is considered; a cache_ack before then is ignored.
- R7: For power-down (mode 2), pwr_off and core_rst are high in entry and idle. Entry waits for pwr_ack. In exit, pwr_off drops first and pwr_ack is awaited, then cache_ack. core_rst and clk_gate are released together on the return to run.
- R8: The mode is captured with the request, so later changes on idle_mode have no effect. Mode code 3 runs the standby sequence, and every sequence returns the controller to standby as its default.
- R9: A request with skip_prep high goes from run straight to entry.
- R10: ack_err is set when pwr_ack stays low for tmo_limit consecutive waiting cycles of a rail change. It stays set until reset, and a tmo_limit of 0 disables it.
- R11: resume_pulse is high for exactly the one cycle in which run is re-entered after exit.
- R12: During reset, phase is run and every control output, pulse and ack_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_req | input | 1 | Request to start an idle sequence (sampled in run) |
| idle_mode | input | 2 | 0 standby, 1 retention, 2 power-down, 3 standby |
| skip_prep | input | 1 | Skip the abortable preparation phase |
| wake | input | 1 | Wake-up event pending |
| all_idle | input | 1 | All cores of the cluster are idle |
| prep_done | input | 1 | Preparation work finished |
| pwr_ack | input | 1 | Power-good acknowledge for a rail change |
| cache_ack | input | 1 | Cache hierarchy confirmed out of standby |
| tmo_limit | input | TMO_W | Acknowledge timeout in cycles, 0 disables |
| phase | output | 3 | Current phase code |
| clk_gate | output | 1 | Core clock gated |
| ret_en | output | 1 | Supply at retention level |
| pwr_off | output | 1 | Core supply removed |
| cache_stby | output | 1 | Cache hierarchy in standby |
| core_rst | output | 1 | Core held in reset |
| abort_pulse | output | 1 | One-cycle pulse on a cancelled sequence |
| resume_pulse | output | 1 | One-cycle pulse when the core resumes |
| ack_err | output | 1 | Sticky acknowledge timeout flag |

## Verification
The bench builds the block with TMO_W set to 4. This makes the full timeout range, up to the 15-cycle limit used during the vector walk, reachable within a few cycles. A limit of 4 shows the flag rising on the fourth unacknowledged cycle and not on the third, and a limit of 0 shows the disabled case over a long wait. The vectors run each mode with and without preparation, a cancel in which wake and prep_done arrive together, a wake held across entry, and acknowledges that arrive early and must be ignored.

// File: rtl/cis_pkg.sv
// Shared types for the core idle sequencer.
// Assumes: phase codes are decoded by neighbouring logic and stay fixed.
package cis_pkg;
    localparam int PHASE_W = 3;
    localparam int MODE_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        MD_STBY = 2'd0,
        MD_RET  = 2'd1,
        MD_PD   = 2'd2,
        MD_DFLT = 2'd3
    } mode_t;

    typedef enum logic [PHASE_W-1:0] {
        PH_RUN   = 3'd0,
        PH_PREP  = 3'd1,
        PH_ENTRY = 3'd2,
        PH_IDLE  = 3'd3,
        PH_EXIT  = 3'd4
    } phase_t;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_PREP,
        ST_ENT,
        ST_IDLE,
        ST_XPWR,
        ST_XCACHE
    } step_t;
endpackage

// File: rtl/cis_ack_timer.sv
// Counts consecutive unacknowledged cycles of a rail change and raises a
// sticky error once the programmed limit is reached.
// Assumes: waiting is high only while a power-good acknowledge is awaited.
module cis_ack_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             waiting,
    input  logic             ack,
    input  logic [TMO_W-1:0] limit,
    output logic             err
);
    localparam logic [TMO_W-1:0] ONE = {{(TMO_W-1){1'b0}}, 1'b1};

    logic [TMO_W-1:0] cnt;

    // Wait counter and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            err <= 1'b0;
        end else if (waiting && !ack && (limit != '0)) begin
            if (cnt == limit - ONE) begin
                err <= 1'b1;
            end else begin
                cnt <= cnt + ONE;
            end
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/cis_fsm.sv
// Step sequencer: walks run, prepare, entry, idle, exit and captures the
// mode at request time. Emits cancel and resume pulses.
// Assumes: acknowledges are level signals held until consumed.
module cis_fsm
    import cis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_req,
    input  logic [MODE_W-1:0] idle_mode,
    input  logic              skip_prep,
    input  logic              wake,
    input  logic              prep_done,
    input  logic              pwr_ack,
    input  logic              cache_ack,
    output step_t             st,
    output mode_t             mode_q,
    output logic              abort_o,
    output logic              resume_o
);
    step_t nxt;
    mode_t req_mode;

    // Map the reserved mode code onto the default standby sequence.
    always_comb begin
        if (mode_t'(idle_mode) == MD_DFLT) req_mode = MD_STBY;
        else                               req_mode = mode_t'(idle_mode);
    end

    // Next-step selection.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_RUN:    if (idle_req) nxt = skip_prep ? ST_ENT : ST_PREP;
            ST_PREP:   if (wake) nxt = ST_RUN;
                       else if (prep_done) nxt = ST_ENT;
            ST_ENT:    if (mode_q == MD_STBY || pwr_ack) nxt = ST_IDLE;
            ST_IDLE:   if (wake) nxt = (mode_q == MD_STBY) ? ST_XCACHE : ST_XPWR;
            ST_XPWR:   if (pwr_ack) nxt = ST_XCACHE;
            ST_XCACHE: if (cache_ack) nxt = ST_RUN;
            default:   nxt = ST_RUN;
        endcase
    end

    // Step register, captured mode and one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_RUN;
            mode_q   <= MD_STBY;
            abort_o  <= 1'b0;
            resume_o <= 1'b0;
        end else begin
            st       <= nxt;
            abort_o  <= (st == ST_PREP) && (nxt == ST_RUN);
            resume_o <= (st == ST_XCACHE) && (nxt == ST_RUN);
            if (st == ST_RUN && idle_req) begin
                mode_q <= req_mode;
            end else if (nxt == ST_RUN) begin
                mode_q <= MD_STBY;
            end
        end
    end
endmodule

// File: rtl/cis_out_decode.sv
// Decodes step and captured mode into the power controls and phase code.
// Assumes: outputs are consumed as levels; cache standby follows all_idle live.
module cis_out_decode
    import cis_pkg::*;
(
    input  step_t              st,
    input  mode_t              mode_q,
    input  logic               all_idle,
    output logic [PHASE_W-1:0] phase,
    output logic               clk_gate,
    output logic               ret_en,
    output logic               pwr_off,
    output logic               cache_stby,
    output logic               core_rst,
    output logic               waiting
);
    logic low_side;
    logic gated;

    // Phase code and control levels per step.
    always_comb begin
        unique case (st)
            ST_RUN:            phase = PH_RUN;
            ST_PREP:           phase = PH_PREP;
            ST_ENT:            phase = PH_ENTRY;
            ST_IDLE:           phase = PH_IDLE;
            ST_XPWR, ST_XCACHE: phase = PH_EXIT;
            default:           phase = PH_RUN;
        endcase
        low_side   = (st == ST_ENT) || (st == ST_IDLE);
        gated      = low_side || (st == ST_XPWR) || (st == ST_XCACHE);
        clk_gate   = gated;
        ret_en     = low_side && (mode_q == MD_RET);
        pwr_off    = low_side && (mode_q == MD_PD);
        core_rst   = gated && (mode_q == MD_PD);
        cache_stby = (st == ST_IDLE) && all_idle;
        waiting    = ((st == ST_ENT) && (mode_q != MD_STBY)) || (st == ST_XPWR);
    end
endmodule

// File: rtl/core_idle_seq.sv
// Core idle entry/exit sequencer top: step sequencer, output decode and
// acknowledge timeout.
// Assumes: all inputs are synchronous to clk.
module core_idle_seq
    import cis_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idle_req,
    input  logic [MODE_W-1:0]  idle_mode,
    input  logic               skip_prep,
    input  logic               wake,
    input  logic               all_idle,
    input  logic               prep_done,
    input  logic               pwr_ack,
    input  logic               cache_ack,
    input  logic [TMO_W-1:0]   tmo_limit,
    output logic [PHASE_W-1:0] phase,
    output logic               clk_gate,
    output logic               ret_en,
    output logic               pwr_off,
    output logic               cache_stby,
    output logic               core_rst,
    output logic               abort_pulse,
    output logic               resume_pulse,
    output logic               ack_err
);
    step_t st;
    mode_t mode_q;
    logic  waiting;

    cis_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_req  (idle_req),
        .idle_mode (idle_mode),
        .skip_prep (skip_prep),
        .wake      (wake),
        .prep_done (prep_done),
        .pwr_ack   (pwr_ack),
        .cache_ack (cache_ack),
        .st        (st),
        .mode_q    (mode_q),
        .abort_o   (abort_pulse),
        .resume_o  (resume_pulse)
    );

    cis_out_decode u_dec (
        .st         (st),
        .mode_q     (mode_q),
        .all_idle   (all_idle),
        .phase      (phase),
        .clk_gate   (clk_gate),
        .ret_en     (ret_en),
        .pwr_off    (pwr_off),
        .cache_stby (cache_stby),
        .core_rst   (core_rst),
        .waiting    (waiting)
    );

    cis_ack_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .waiting (waiting),
        .ack     (pwr_ack),
        .limit   (tmo_limit),
        .err     (ack_err)
    );
endmodule

// File: rtl/cis_checker.sv
// Property checker for core_idle_seq, attached by bind; observes ports only.
// Assumes: reset is synchronous and active low.
module cis_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wake,
    input logic       idle_req,
    input logic       skip_prep,
    input logic       cache_ack,
    input logic [2:0] phase,
    input logic       clk_gate,
    input logic       pwr_off,
    input logic       core_rst,
    input logic       abort_pulse,
    input logic       resume_pulse,
    input logic       ack_err
);
    AST_IDLE_TO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd3 |=> (phase == 3'd3 || phase == 3'd4)); // R1

    AST_PREP_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1 && wake) |=> (phase == 3'd0 && abort_pulse)); // R2

    AST_ENTRY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd2 |=> (phase == 3'd2 || phase == 3'd3)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3 && !wake) |=> phase == 3'd3); // R4

    AST_CLK_AFTER_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_gate) |-> $past(cache_ack)); // R5

    AST_RST_AFTER_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> !pwr_off); // R7

    AST_SKIP_PREP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd0 && idle_req && skip_prep) |=> phase == 3'd2); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |=> ack_err); // R10

    AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse); // R11

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_pulse && resume_pulse)); // R11
endmodule

bind core_idle_seq cis_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake         (wake),
    .idle_req     (idle_req),
    .skip_prep    (skip_prep),
    .cache_ack    (cache_ack),
    .phase        (phase),
    .clk_gate     (clk_gate),
    .pwr_off      (pwr_off),
    .core_rst     (core_rst),
    .abort_pulse  (abort_pulse),
    .resume_pulse (resume_pulse),
    .ack_err      (ack_err)
);

// File: tb/core_idle_seq_tb.sv
`timescale 1ns/1ps
module core_idle_seq_tb;
    localparam int TMO_W = 4;
    localparam int NVEC  = 32;
    // Vector layout: {tag[3:0], in[8:0], exp[9:0]}
    // in  = {req, mode[1:0], skip, wake, all_idle, prep_done, pwr_ack, cache_ack}
    // exp = {phase[2:0], clk_gate, ret_en, pwr_off, cache_stby, core_rst, abort, resume}
    localparam logic [22:0] VEC [NVEC] = '{
        {4'd1,  9'b1_00_0_0_0_0_0_0, 10'b001_0_0_0_0_0_0_0}, // R1 request -> prepare
        {4'd2,  9'b0_00_0_0_0_0_0_0, 10'b001_0_0_0_0_0_0_0}, // R2 waits prep_done
        {4'd1,  9'b0_00_0_0_0_1_0_0, 10'b010_1_0_0_0_0_0_0}, // R1 -> entry
        {4'd5,  9'b0_00_0_0_0_0_0_0, 10'b011_1_0_0_0_0_0_0}, // R5 standby entry one cycle
        {4'd5,  9'b0_00_0_0_1_0_0_0, 10'b011_1_0_0_1_0_0_0}, // R5 cache standby with all_idle
        {4'd5,  9'b0_00_0_1_1_0_0_0, 10'b100_1_0_0_0_0_0_0}, // R5 wake -> exit
        {4'd5,  9'b0_00_0_0_0_0_0_0, 10'b100_1_0_0_0_0_0_0}, // R5 clock held w/o cache_ack
        {4'd11, 9'b0_00_0_0_0_0_0_1, 10'b000_0_0_0_0_0_0_1}, // R11 resume pulse
        {4'd11, 9'b0_00_0_0_0_0_0_0, 10'b000_0_0_0_0_0_0_0}, // R11 pulse single
        {4'd2,  9'b1_00_0_0_0_0_0_0, 10'b001_0_0_0_0_0_0_0}, // R2 prepare again
        {4'd2,  9'b0_00_0_1_0_1_0_0, 10'b000_0_0_0_0_0_1_0}, // R2 wake beats prep_done
        {4'd2,  9'b0_00_0_0_0_0_0_0, 10'b000_0_0_0_0_0_0_0}, // R2 abort single
        {4'd9,  9'b1_01_1_0_0_0_0_0, 10'b010_1_1_0_0_0_0_0}, // R9 skip -> entry
        {4'd3,  9'b0_00_0_1_0_0_0_0, 10'b010_1_1_0_0_0_0_0}, // R3 wake ignored in entry
        {4'd6,  9'b0_00_0_1_0_0_1_0, 10'b011_1_1_0_0_0_0_0}, // R6 pwr_ack -> idle
        {4'd3,  9'b0_00_0_1_0_0_0_0, 10'b100_1_0_0_0_0_0_0}, // R3 held wake -> exit
        {4'd6,  9'b0_00_0_0_0_0_0_1, 10'b100_1_0_0_0_0_0_0}, // R6 early cache_ack ignored
        {4'd6,  9'b0_00_0_0_0_0_1_0, 10'b100_1_0_0_0_0_0_0}, // R6 supply restored
        {4'd6,  9'b0_00_0_0_0_0_0_1, 10'b000_0_0_0_0_0_0_1}, // R6 resume
        {4'd7,  9'b1_10_0_0_0_0_0_0, 10'b001_0_0_0_0_0_0_0}, // R7 power-down prepare
        {4'd8,  9'b0_00_0_0_0_1_0_0, 10'b010_1_0_1_0_1_0_0}, // R8 mode latched despite change
        {4'd7,  9'b0_00_0_0_0_0_1_0, 10'b011_1_0_1_0_1_0_0}, // R7 supply off -> idle
        {4'd4,  9'b0_00_0_0_0_0_0_0, 10'b011_1_0_1_0_1_0_0}, // R4 idle holds
        {4'd4,  9'b0_00_0_0_1_0_0_0, 10'b011_1_0_1_1_1_0_0}, // R4 idle holds
        {4'd7,  9'b0_00_0_1_0_0_0_0, 10'b100_1_0_0_0_1_0_0}, // R7 supply restore first
        {4'd7,  9'b0_00_0_0_0_0_1_0, 10'b100_1_0_0_0_1_0_0}, // R7 await cache
        {4'd7,  9'b0_00_0_0_0_0_0_1, 10'b000_0_0_0_0_0_0_1}, // R7 reset released
        {4'd8,  9'b1_11_1_0_0_0_0_0, 10'b010_1_0_0_0_0_0_0}, // R8 code 3 is standby
        {4'd8,  9'b0_00_0_0_0_0_0_0, 10'b011_1_0_0_0_0_0_0}, // R8 no rail wait
        {4'd5,  9'b0_00_0_1_0_0_0_1, 10'b100_1_0_0_0_0_0_0}, // R5 cache_ack in idle ignored
        {4'd5,  9'b0_00_0_0_0_0_0_1, 10'b000_0_0_0_0_0_0_1}, // R5 resume
        {4'd1,  9'b0_00_0_0_0_0_0_0, 10'b000_0_0_0_0_0_0_0}  // R1 run holds
    };

    logic clk = 1'b0;
    logic rst_n;
    logic idle_req, skip_prep, wake, all_idle, prep_done, pwr_ack, cache_ack;
    logic [1:0] idle_mode;
    logic [TMO_W-1:0] tmo_limit;
    logic [2:0] phase;
    logic clk_gate, ret_en, pwr_off, cache_stby, core_rst;
    logic abort_pulse, resume_pulse, ack_err;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    core_idle_seq #(.TMO_W(TMO_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_mode(idle_mode),
        .skip_prep(skip_prep), .wake(wake), .all_idle(all_idle),
        .prep_done(prep_done), .pwr_ack(pwr_ack), .cache_ack(cache_ack),
        .tmo_limit(tmo_limit), .phase(phase), .clk_gate(clk_gate),
        .ret_en(ret_en), .pwr_off(pwr_off), .cache_stby(cache_stby),
        .core_rst(core_rst), .abort_pulse(abort_pulse),
        .resume_pulse(resume_pulse), .ack_err(ack_err)
    );

    function automatic logic [9:0] outs();
        return {phase, clk_gate, ret_en, pwr_off, cache_stby, core_rst,
                abort_pulse, resume_pulse};
    endfunction

    task automatic drive(input logic [8:0] v);
        {idle_req, idle_mode, skip_prep, wake, all_idle, prep_done,
         pwr_ack, cache_ack} = v;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(9'b0);
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tmo_limit = 4'd15;
        // R12 reset state
        rst_n = 1'b0;
        drive(9'b0);
        tick();
        tick();
        chk("R12", {outs(), ack_err}, 11'b0);
        rst_n = 1'b1;

        // Vector walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][18:10]);
            tick();
            chk($sformatf("R%0d vec%0d", VEC[i][22:19], i), {1'b0, outs()},
                {1'b0, VEC[i][9:0]});
        end
        chk("R10 no timeout in walk", {10'b0, ack_err}, 11'b0);

        // R10 timeout at limit 4: rises on fourth unacknowledged cycle
        do_reset();
        tmo_limit = 4'd4;
        drive(9'b1_01_1_0_0_0_0_0);
        tick();
        drive(9'b0);
        tick(); tick(); tick();
        chk("R10 before limit", {10'b0, ack_err}, 11'b0);
        tick();
        chk("R10 at limit", {10'b0, ack_err}, 11'b1);
        drive(9'b0_00_0_0_0_0_1_0);
        tick();
        drive(9'b0);
        tick();
        chk("R10 sticky", {outs(), ack_err}, {10'b011_1_1_0_0_0_0_0, 1'b1});

        // R12 reset clears the flag mid-sequence
        do_reset();
        #1;
        chk("R12 after reset", {outs(), ack_err}, 11'b0);

        // R10 limit 0 disables the timeout
        tmo_limit = 4'd0;
        drive(9'b1_10_1_0_0_0_0_0);
        tick();
        drive(9'b0);
        for (int k = 0; k < 20; k++) tick();
        chk("R10 disabled", {outs(), ack_err}, {10'b010_1_0_1_0_1_0_0, 1'b0});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule